// File: doc/BRIEF.md
# CTS/RTS Hardware Flow Controller

This block sits between the character source of a UART transmitter and its serializer, and between the receive buffer and the RTS pin. On the transmit side it holds one written character and commands the serializer to begin sending it. When CTS gating is on, a character may begin only while the synchronized CTS input is low. A character that is already being shifted out always runs to completion. A character written while CTS is high waits in the slot until CTS goes low again. So flow control acts only between characters.

On the receive side it drives RTS low whenever RTS generation is enabled and the receiver reports room for another character, and high otherwise. The CTS input is brought into the clock domain through a synchronizer chain. Every edge of the synchronized level sets a change flag that a clear strobe resets. The flag, qualified by an interrupt enable, forms the CTS interrupt request.

The write interface is valid/ready. `wr_ready` is high while the one-character slot is empty. A write is accepted on a rising clock edge when both `wr_valid` and `wr_ready` are high. While the slot is full, `wr_ready` stays low and `wr_valid` has no effect, whatever CTS or the serializer is doing. The serializer side is a plain command pulse `start_char` and a completion pulse `char_done`.

Top module: `flow_ctrl_top`

## Requirements
- R1: After reset `wr_ready` is 1, `start_char` is 0, `tx_busy` is 0, `rts_out` is 1, `cts_chg_flag` is 0 and `cts_irq` is 0.
- R2: With `cts_gate_en`=1 and the synchronized CTS low, an accepted write with the serializer idle raises `start_char` in the cycle after the accepting edge, and `tx_busy` goes to 1 on the next edge.
- R3: With `cts_gate_en`=1, a character written while CTS is high is not started; `start_char` rises in the second cycle after CTS is driven low, counting from the first rising edge after the change.
- R4: CTS going high while `tx_busy`=1 does not end the character; `tx_busy` falls only after a `char_done` pulse, and a held character then waits for CTS low.
- R5: With `cts_gate_en`=0, the CTS input has no effect on starting characters.
- R6: `rts_out` is registered; one cycle after the inputs settle it is 0 when `rts_gen_en`=1 and `rx_space`=1, and it is 1 otherwise.
- R7: Any edge of the synchronized CTS sets `cts_chg_flag`; `cts_chg_clr` clears it; `cts_irq` equals `cts_chg_flag` AND `cts_irq_en`.
- R8: While the slot is full, `wr_ready` is 0 and a held `wr_valid` is not taken, so it produces no extra `start_char`.
- R9: `start_char` is never raised while `tx_busy`=1; a character written during a transfer starts in the cycle after the edge that sees `char_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_gate_en | input | 1 | Enables CTS gating of character starts |
| rts_gen_en | input | 1 | Enables RTS generation |
| cts_irq_en | input | 1 | Enables the CTS change interrupt |
| cts_in | input | 1 | Asynchronous CTS input, low means clear to send |
| wr_valid | input | 1 | Transmit character write request |
| wr_ready | output | 1 | Character slot empty, write accepted |
| start_char | output | 1 | Command to the serializer to begin a character |
| char_done | input | 1 | Serializer finished the current character |
| tx_busy | output | 1 | A character is in flight in the serializer |
| rx_space | input | 1 | Receive buffer can take another character |
| rts_out | output | 1 | RTS pin, low means request to send |
| cts_chg_clr | input | 1 | Clears the CTS change flag |
| cts_chg_flag | output | 1 | Synchronized CTS changed since last clear |
| cts_irq | output | 1 | CTS change interrupt request |

## Verification
On every cycle the assertions check the following:
- no character starts while gating is on and synchronized CTS is high;
- a start is always followed by busy;
- busy ends only after a completion pulse;
- an accepted write leaves the slot full on the next cycle;
- RTS follows its enable one cycle later;
- each synchronized edge sets the change flag.

Only the directed scenarios can show how these combine over time. They cover how many cycles a held character waits after CTS drops, and that a character in flight survives CTS rising. They also show that a write refused under back-pressure never turns into an extra start.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic held;   // character written, not yet started
    logic flight; // character being shifted by serializer
  } tx_slot_t;
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int unsigned STAGES = flow_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic chg_clr,
  output logic cts_sync,
  output logic chg_flag
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              edge_seen;
  logic              flag_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= cts_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign cts_sync  = chain_q[STAGES-1];
  assign edge_seen = cts_sync ^ prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= cts_sync;
      if (edge_seen)    flag_q <= 1'b1;
      else if (chg_clr) flag_q <= 1'b0;
    end
  end

  assign chg_flag = flag_q;

  // R7
  flag_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> chg_flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !edge_seen) |=> !chg_flag);
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_en,
  input  logic cts_sync,
  input  logic wr_valid,
  output logic wr_ready,
  output logic start_char,
  input  logic char_done,
  output logic tx_busy
);
  import flow_pkg::*;

  tx_slot_t slot_q, slot_d;
  logic     clear_to_send;
  logic     accept;

  assign clear_to_send = !gate_en || !cts_sync;
  assign wr_ready      = !slot_q.held;
  assign accept        = wr_valid && wr_ready;
  assign start_char    = slot_q.held && !slot_q.flight && clear_to_send;
  assign tx_busy       = slot_q.flight;

  always_comb begin
    slot_d = slot_q;
    if (char_done)  slot_d.flight = 1'b0;
    if (start_char) begin
      slot_d.held   = 1'b0;
      slot_d.flight = 1'b1;
    end
    if (accept)     slot_d.held = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_char |=> tx_busy);
  // R4
  busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(char_done));
  // R8
  slot_full_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
endmodule

// File: rtl/flow_rts_gen.sv
module flow_rts_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_gen_en,
  input  logic rx_space,
  output logic rts_out
);
  logic rts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rts_q <= 1'b1;
    else        rts_q <= !(rts_gen_en && rx_space);
  end

  assign rts_out = rts_q;

  // R6
  rts_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_gen_en |=> rts_out);
  // R6
  rts_off_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_space |=> rts_out);
endmodule

// File: rtl/flow_ctrl_top.sv
module flow_ctrl_top #(
  parameter int unsigned SYNC_STAGES = flow_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_gate_en,
  input  logic rts_gen_en,
  input  logic cts_irq_en,
  input  logic cts_in,
  input  logic wr_valid,
  output logic wr_ready,
  output logic start_char,
  input  logic char_done,
  output logic tx_busy,
  input  logic rx_space,
  output logic rts_out,
  input  logic cts_chg_clr,
  output logic cts_chg_flag,
  output logic cts_irq
);
  logic cts_sync;

  flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_in   (cts_in),
    .chg_clr  (cts_chg_clr),
    .cts_sync (cts_sync),
    .chg_flag (cts_chg_flag)
  );

  flow_tx_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_en    (cts_gate_en),
    .cts_sync   (cts_sync),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .start_char (start_char),
    .char_done  (char_done),
    .tx_busy    (tx_busy)
  );

  flow_rts_gen u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .rts_gen_en (rts_gen_en),
    .rx_space   (rx_space),
    .rts_out    (rts_out)
  );

  assign cts_irq = cts_chg_flag && cts_irq_en;

  // R3
  no_start_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_char && cts_gate_en) |-> !cts_sync);
  // R9
  no_start_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !start_char);
endmodule

// File: tb/test_flow_ctrl_top.sv
module test_flow_ctrl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_gate_en = 1'b1, rts_gen_en = 1'b0, cts_irq_en = 1'b0;
  logic cts_in = 1'b0, wr_valid = 1'b0, char_done = 1'b0;
  logic rx_space = 1'b0, cts_chg_clr = 1'b0;
  logic wr_ready, start_char, tx_busy, rts_out, cts_chg_flag, cts_irq;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flow_ctrl_top i_flow_ctrl_top (
    .clk(clk), .rst_n(rst_n), .cts_gate_en(cts_gate_en), .rts_gen_en(rts_gen_en),
    .cts_irq_en(cts_irq_en), .cts_in(cts_in), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .start_char(start_char), .char_done(char_done),
    .tx_busy(tx_busy), .rx_space(rx_space), .rts_out(rts_out),
    .cts_chg_clr(cts_chg_clr), .cts_chg_flag(cts_chg_flag), .cts_irq(cts_irq)
  );

  always @(posedge clk) if (rst_n && start_char) starts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write();
    @(negedge clk) wr_valid = 1'b1;
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk) char_done = 1'b1;
    @(negedge clk) char_done = 1'b0;
  endtask

  task automatic test_reset();
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    chk(start_char == 0, "R1 start_char", start_char, 0);
    chk(tx_busy == 0, "R1 tx_busy", tx_busy, 0);
    chk(rts_out == 1, "R1 rts_out", rts_out, 1);
    chk(cts_chg_flag == 0 && cts_irq == 0, "R1 flag/irq", cts_chg_flag, 0);
  endtask

  task automatic test_basic_start();
    do_write();
    chk(start_char == 1, "R2 start after write", start_char, 1);
    @(negedge clk);
    chk(tx_busy == 1, "R2 busy after start", tx_busy, 1);
    chk(wr_ready == 1, "R2 slot freed", wr_ready, 1);
    pulse_done();
    chk(tx_busy == 0, "R2 idle after done", tx_busy, 0);
  endtask

  task automatic test_cts_hold();
    int s0;
    cts_in = 1'b1;
    wait_n(4);
    do_write();
    s0 = starts;
    for (int i = 0; i < 8; i++) begin
      chk(start_char == 0, "R3 held while cts high", start_char, 0);
      @(negedge clk);
    end
    chk(wr_ready == 0 && starts == s0, "R3 slot still held", wr_ready, 0);
    cts_in = 1'b0;
    @(negedge clk);
    chk(start_char == 0, "R3 one edge after cts low", start_char, 0);
    @(negedge clk);
    chk(start_char == 1, "R3 start two edges after cts low", start_char, 1);
    @(negedge clk);
    pulse_done();
  endtask

  task automatic test_mid_char();
    do_write();
    @(negedge clk);
    chk(tx_busy == 1, "R4 in flight", tx_busy, 1);
    cts_in = 1'b1;
    wait_n(4);
    chk(tx_busy == 1, "R4 char not cut by cts", tx_busy, 1);
    do_write();
    pulse_done();
    chk(tx_busy == 0, "R4 done ends char", tx_busy, 0);
    for (int i = 0; i < 4; i++) begin
      chk(start_char == 0, "R4 next waits for cts", start_char, 0);
      @(negedge clk);
    end
    cts_in = 1'b0;
    wait_n(2);
    chk(start_char == 1, "R4 next starts after cts low", start_char, 1);
    @(negedge clk);
    pulse_done();
  endtask

  task automatic test_gate_off();
    cts_gate_en = 1'b0;
    cts_in = 1'b1;
    wait_n(4);
    do_write();
    chk(start_char == 1, "R5 cts ignored when gating off", start_char, 1);
    @(negedge clk);
    pulse_done();
    cts_gate_en = 1'b1;
    cts_in = 1'b0;
    wait_n(4);
  endtask

  task automatic test_backpressure();
    int s0;
    do_write();
    @(negedge clk);
    do_write();
    chk(wr_ready == 0, "R8 slot full", wr_ready, 0);
    s0 = starts;
    wr_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(start_char == 0, "R9 no start while busy", start_char, 0);
    end
    wr_valid = 1'b0;
    @(negedge clk) char_done = 1'b1;
    @(negedge clk) char_done = 1'b0;
    chk(start_char == 1, "R9 start right after done", start_char, 1);
    @(negedge clk);
    pulse_done();
    wait_n(4);
    chk(starts == s0 + 1, "R8 refused write not sent", starts, s0 + 1);
  endtask

  task automatic test_rts();
    rts_gen_en = 1'b1; rx_space = 1'b1;
    wait_n(1);
    chk(rts_out == 0, "R6 rts low with room", rts_out, 0);
    rx_space = 1'b0;
    wait_n(1);
    chk(rts_out == 1, "R6 rts high when full", rts_out, 1);
    rx_space = 1'b1; rts_gen_en = 1'b0;
    wait_n(1);
    chk(rts_out == 1, "R6 rts high when disabled", rts_out, 1);
  endtask

  task automatic test_cts_flag();
    @(negedge clk) cts_chg_clr = 1'b1;
    @(negedge clk) cts_chg_clr = 1'b0;
    chk(cts_chg_flag == 0, "R7 cleared", cts_chg_flag, 0);
    cts_irq_en = 1'b0;
    cts_in = 1'b1;
    wait_n(4);
    chk(cts_chg_flag == 1, "R7 rising edge sets flag", cts_chg_flag, 1);
    chk(cts_irq == 0, "R7 irq masked", cts_irq, 0);
    cts_irq_en = 1'b1;
    #1;
    chk(cts_irq == 1, "R7 irq enabled", cts_irq, 1);
    @(negedge clk) cts_chg_clr = 1'b1;
    @(negedge clk) cts_chg_clr = 1'b0;
    chk(cts_chg_flag == 0 && cts_irq == 0, "R7 clear strobe", cts_chg_flag, 0);
    cts_in = 1'b0;
    wait_n(4);
    chk(cts_chg_flag == 1, "R7 falling edge sets flag", cts_chg_flag, 1);
  endtask

  initial begin
    wait_n(3);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic_start();
    test_cts_hold();
    test_mid_char();
    test_gate_off();
    test_backpressure();
    test_rts();
    test_cts_flag();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule